// File: doc/BRIEF.md
# Table-Keyed XOR Byte Scrambler Pair

This block holds a transmit path and a receive path that hide 8-bit data words by XOR with a code drawn from a fixed 16-entry table. For every accepted transmit word, a free-running 8-bit LFSR supplies a pseudo-random 4-bit index into the table. The data byte is XORed with the selected code. The scrambled byte leaves the block together with an 8-bit side field. The receive path takes a scrambled byte and side field and returns the original byte.

A shared mode input selects what the side field carries. In plain-code mode it carries the code itself. In inverted mode, both the scrambled byte and the code are sent bit-inverted. In index mode it carries only the table index, and the receiver finds the code in its own copy of the table. Each path has one register stage. Every bit of both XOR stages is built from four 2-input NAND gates.

Top module: `tblxor_scrambler`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `txOutValid` and `rxOutValid` are 0, and `txByte`, `txSide` and `rxData` are 0.
- R2: The code table, indexed 0 to 15, holds hex FF, AA, 55, CC, 33, F0, 0F, C3, E7, 18, C3, 3C, 81, 7E, CF, F3. Indices 7 and 10 both map to C3.
- R3: The `modeSel` encoding is 0 = plain-code, 1 = inverted, 2 = index, and 3 = plain-code. The same value applies to both paths in the cycle in which each word is accepted.
- R4: Transmit in plain-code mode: `txSide` equals one of the table codes, and `txByte` equals `txData` XOR `txSide`.
- R5: Transmit in inverted mode: `~txSide` equals one of the table codes, and `txByte` equals the bitwise inverse of (`txData` XOR that code).
- R6: Transmit in index mode: `txSide[7:4]` is 0, and `txByte` equals `txData` XOR the table code at index `txSide[3:0]`.
- R7: Receive in plain-code mode: `rxData` equals `rxByte` XOR `rxSide`.
- R8: Receive in inverted mode: `rxData` equals (`~rxByte`) XOR (`~rxSide`).
- R9: Receive in index mode: `rxData` equals `rxByte` XOR the table code at index `rxSide[3:0]`. The bits `rxSide[7:4]` have no effect on the result.
- R10: `txOutValid` is high in exactly the cycle after each cycle with `txValid` high. `rxOutValid` follows `rxValid` in the same way.
- R11: When a path's input valid is low, that path's data outputs hold their previous values.
- R12: Across 64 transmit words accepted on consecutive cycles in index mode, at least 8 distinct indices appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Framing mode for both paths |
| txValid | input | 1 | Transmit word present |
| txData | input | 8 | Plain transmit byte |
| txOutValid | output | 1 | Scrambled word present |
| txByte | output | 8 | Scrambled byte |
| txSide | output | 8 | Side field (code, inverted code, or index) |
| rxValid | input | 1 | Receive word present |
| rxByte | input | 8 | Received scrambled byte |
| rxSide | input | 8 | Received side field |
| rxOutValid | output | 1 | Recovered word present |
| rxData | output | 8 | Recovered byte |

## Verification
The transmit index comes from internal LFSR state that the ports do not show. The bench therefore checks transmit results through relations that hold for any index: it requires table membership of the recovered code and round-trip recovery through the receive path. Duplicate table entry 7 and non-zero upper side bits in index mode are hard to reach through the transmit path. The bench drives them directly into the receive path, sweeping all 16 indices with garbage in `rxSide[7:4]`. Index spread is checked by streaming 64 back-to-back words and counting the distinct side values.

// File: rtl/tblxor_pkg.sv
package tblxor_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 4;
  localparam int TBL_N  = 1 << IDX_W;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_INV   = 2'd1,
    MODE_INDEX = 2'd2
  } frame_mode_t;

  typedef struct packed {
    logic             txLoad;
    logic             rxLoad;
    logic [IDX_W-1:0] txIdx;
    frame_mode_t      mode;
  } strobe_t;

  function automatic frame_mode_t decodeMode(input logic [1:0] sel);
    case (sel)
      2'd1:    return MODE_INV;
      2'd2:    return MODE_INDEX;
      default: return MODE_PLAIN;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] codeLookup(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:  return 8'hFF;
      4'd1:  return 8'hAA;
      4'd2:  return 8'h55;
      4'd3:  return 8'hCC;
      4'd4:  return 8'h33;
      4'd5:  return 8'hF0;
      4'd6:  return 8'h0F;
      4'd7:  return 8'hC3;
      4'd8:  return 8'hE7;
      4'd9:  return 8'h18;
      4'd10: return 8'hC3;
      4'd11: return 8'h3C;
      4'd12: return 8'h81;
      4'd13: return 8'h7E;
      4'd14: return 8'hCF;
      default: return 8'hF3;
    endcase
  endfunction
endpackage

// File: rtl/tblxor_nand_xor.sv
module tblxor_nand_xor #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic n1, n2, n3;
    assign n1 = ~(opA[b] & opB[b]);
    assign n2 = ~(opA[b] & n1);
    assign n3 = ~(n1 & opB[b]);
    assign result[b] = ~(n2 & n3);
  end
endmodule

// File: rtl/tblxor_ctrl.sv
module tblxor_ctrl
  import tblxor_pkg::*;
#(
  parameter int          LFSR_W    = 8,
  parameter logic [7:0]  LFSR_SEED = 8'h01
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       txValid,
  input  logic       rxValid,
  output strobe_t    strobes,
  output logic       txOutValid,
  output logic       rxOutValid
);
  logic [LFSR_W-1:0] lfsrQ;
  logic              feedback;

  assign feedback = lfsrQ[7] ^ lfsrQ[5] ^ lfsrQ[4] ^ lfsrQ[3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ      <= LFSR_SEED[LFSR_W-1:0];
      txOutValid <= 1'b0;
      rxOutValid <= 1'b0;
    end else begin
      lfsrQ      <= {lfsrQ[LFSR_W-2:0], feedback};
      txOutValid <= txValid;
      rxOutValid <= rxValid;
    end
  end

  always_comb begin
    strobes.txLoad = txValid;
    strobes.rxLoad = rxValid;
    strobes.txIdx  = lfsrQ[IDX_W-1:0];
    strobes.mode   = decodeMode(modeSel);
  end
endmodule

// File: rtl/tblxor_datapath.sv
module tblxor_datapath
  import tblxor_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] txData,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [DATA_W-1:0] rxSide,
  output logic [DATA_W-1:0] txByte,
  output logic [DATA_W-1:0] txSide,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txCode, txMixed, txByteNext, txSideNext;
  logic [DATA_W-1:0] rxCode, rxOperand, rxMixed;

  assign txCode = codeLookup(strobes.txIdx);

  tblxor_nand_xor #(.WIDTH(DATA_W)) u_txXor (
    .opA(txData), .opB(txCode), .result(txMixed)
  );

  always_comb begin
    case (strobes.mode)
      MODE_INV: begin
        txByteNext = ~txMixed;
        txSideNext = ~txCode;
      end
      MODE_INDEX: begin
        txByteNext = txMixed;
        txSideNext = {{(DATA_W-IDX_W){1'b0}}, strobes.txIdx};
      end
      default: begin
        txByteNext = txMixed;
        txSideNext = txCode;
      end
    endcase
  end

  always_comb begin
    case (strobes.mode)
      MODE_INV: begin
        rxOperand = ~rxByte;
        rxCode    = ~rxSide;
      end
      MODE_INDEX: begin
        rxOperand = rxByte;
        rxCode    = codeLookup(rxSide[IDX_W-1:0]);
      end
      default: begin
        rxOperand = rxByte;
        rxCode    = rxSide;
      end
    endcase
  end

  tblxor_nand_xor #(.WIDTH(DATA_W)) u_rxXor (
    .opA(rxOperand), .opB(rxCode), .result(rxMixed)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txByte <= '0;
      txSide <= '0;
      rxData <= '0;
    end else begin
      if (strobes.txLoad) begin
        txByte <= txByteNext;
        txSide <= txSideNext;
      end
      if (strobes.rxLoad) rxData <= rxMixed;
    end
  end
endmodule

// File: rtl/tblxor_scrambler.sv
module tblxor_scrambler (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       txValid,
  input  logic [7:0] txData,
  output logic       txOutValid,
  output logic [7:0] txByte,
  output logic [7:0] txSide,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic [7:0] rxSide,
  output logic       rxOutValid,
  output logic [7:0] rxData
);
  import tblxor_pkg::*;

  strobe_t strobes;

  tblxor_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .txValid(txValid), .rxValid(rxValid),
    .strobes(strobes), .txOutValid(txOutValid), .rxOutValid(rxOutValid)
  );

  tblxor_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .txData(txData), .rxByte(rxByte), .rxSide(rxSide),
    .txByte(txByte), .txSide(txSide), .rxData(rxData)
  );
endmodule

// File: rtl/tblxor_scrambler_chk.sv
module tblxor_scrambler_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       txValid,
  input logic       txOutValid,
  input logic [7:0] txSide,
  input logic [7:0] txByte,
  input logic       rxValid,
  input logic       rxOutValid,
  input logic [7:0] rxData
);
  // R10
  a_r10_tx_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> txOutValid);
  // R10
  a_r10_rx_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> rxOutValid);
  // R11
  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !txValid |=> ($stable(txByte) && $stable(txSide)));
  // R11
  a_r11_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(rxData));
  // R6
  a_r6_index_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && modeSel == 2'd2) |=> (txSide[7:4] == 4'h0));
endmodule

bind tblxor_scrambler tblxor_scrambler_chk u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel),
  .txValid(txValid), .txOutValid(txOutValid), .txSide(txSide), .txByte(txByte),
  .rxValid(rxValid), .rxOutValid(rxOutValid), .rxData(rxData)
);

// File: tb/tblxor_scrambler_tb.sv
module tblxor_scrambler_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] modeSel;
  logic       txValid, rxValid;
  logic [7:0] txData, rxByte, rxSide;
  logic       txOutValid, rxOutValid;
  logic [7:0] txByte, txSide, rxData;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] refTbl [16];
  bit seenIdx [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  tblxor_scrambler dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .txValid(txValid), .txData(txData), .txOutValid(txOutValid),
    .txByte(txByte), .txSide(txSide),
    .rxValid(rxValid), .rxByte(rxByte), .rxSide(rxSide),
    .rxOutValid(rxOutValid), .rxData(rxData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit inTable(input logic [7:0] v);
    for (int i = 0; i < 16; i++) if (refTbl[i] == v) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] refRx(input logic [1:0] m, input logic [7:0] b, input logic [7:0] s);
    if (m == 2'd1) return (~b) ^ (~s);
    if (m == 2'd2) return b ^ refTbl[s[3:0]];
    return b ^ s;
  endfunction

  // Drive one transmit word, check the result one cycle later, loop it through rx.
  task automatic txWord(input logic [1:0] m, input logic [7:0] d, input string req);
    logic [7:0] code, capB, capS;
    @(negedge clk);
    modeSel = m; txData = d; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    chk(txOutValid === 1'b1, "R10", txOutValid, 1);
    capB = txByte; capS = txSide;
    if (m == 2'd1) begin
      code = ~capS;
      chk(inTable(code), {req, " R5 code"}, code, 0);
      chk(capB === ~(d ^ code), {req, " R5 byte"}, capB, ~(d ^ code));
    end else if (m == 2'd2) begin
      chk(capS[7:4] === 4'h0, {req, " R6 upper"}, capS, capS & 8'h0F);
      chk(capB === (d ^ refTbl[capS[3:0]]), {req, " R6 byte"}, capB, d ^ refTbl[capS[3:0]]);
    end else begin
      chk(inTable(capS), {req, " R4 code"}, capS, 0);
      chk(capB === (d ^ capS), {req, " R4 byte"}, capB, d ^ capS);
    end
    @(negedge clk);
    chk(txOutValid === 1'b0 && txByte === capB && txSide === capS, "R11 tx hold", txByte, capB);
    rxWord(m, capB, capS, 8'h00, "round trip");
    chk(rxData === d, "R3 round trip", rxData, d);
  endtask

  task automatic rxWord(input logic [1:0] m, input logic [7:0] b, input logic [7:0] s,
                        input logic [7:0] junk, input string req);
    logic [7:0] exp;
    exp = refRx(m, b, s);
    @(negedge clk);
    modeSel = m; rxByte = b; rxSide = s | junk; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
    chk(rxOutValid === 1'b1, {req, " R10"}, rxOutValid, 1);
    chk(rxData === exp, req, rxData, exp);
    rxByte = ~b; rxSide = ~s;
    @(negedge clk);
    chk(rxOutValid === 1'b0 && rxData === exp, {req, " R11 rx hold"}, rxData, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int distinct;
    refTbl = '{8'hFF, 8'hAA, 8'h55, 8'hCC, 8'h33, 8'hF0, 8'h0F, 8'hC3,
               8'hE7, 8'h18, 8'hC3, 8'h3C, 8'h81, 8'h7E, 8'hCF, 8'hF3};
    rstN = 1'b0; modeSel = 2'd0; txValid = 0; rxValid = 0;
    txData = 0; rxByte = 0; rxSide = 0;
    repeat (3) @(negedge clk);
    chk(txOutValid === 0 && rxOutValid === 0, "R1 valids", txOutValid, 0);
    chk(txByte === 0 && txSide === 0 && rxData === 0, "R1 data", txByte, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(txOutValid === 0 && txByte === 0 && rxData === 0, "R1 after release", txByte, 0);

    // transmit in each mode, with several data patterns
    foreach (refTbl[k]) begin
      txWord(2'd0, 8'h00 + 8'(k * 17), "R4 plain");
      txWord(2'd1, 8'hA5 ^ 8'(k), "R5 inv");
      txWord(2'd2, 8'h3C + 8'(k), "R6 index");
    end
    txWord(2'd3, 8'h5A, "R3 mode3");
    txWord(2'd3, 8'hFF, "R3 mode3");

    // receive directly: index sweep with junk in upper side bits, incl. entries 7 and 10
    for (int i = 0; i < 16; i++)
      rxWord(2'd2, 8'(8'h96 ^ (i << 3)), 8'(i), 8'hA0, "R9 index sweep");
    rxWord(2'd2, 8'hC3, 8'h07, 8'h00, "R2 entry 7");
    chk(rxData === 8'h00, "R2 entry 7", rxData, 0);
    rxWord(2'd2, 8'hC3, 8'h0A, 8'hF0, "R2 entry 10");
    chk(rxData === 8'h00, "R2 entry 10", rxData, 0);
    rxWord(2'd0, 8'h12, 8'h34, 8'h00, "R7 plain rx");
    rxWord(2'd3, 8'hF0, 8'h0F, 8'h00, "R3 mode3 rx");
    rxWord(2'd1, 8'h81, 8'h7E, 8'h00, "R8 inv rx");
    rxWord(2'd1, 8'h00, 8'hFF, 8'h00, "R8 inv rx");

    // index spread over 64 back-to-back words
    @(negedge clk);
    modeSel = 2'd2; txValid = 1'b1;
    for (int n = 0; n < 64; n++) begin
      txData = 8'(n);
      @(negedge clk);
      seenIdx[txSide[3:0]] = 1;
    end
    txValid = 1'b0;
    distinct = 0;
    for (int i = 0; i < 16; i++) if (seenIdx[i]) distinct++;
    chk(distinct >= 8, "R12 distinct indices", distinct, 8);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule